// File: doc/BRIEF.md
# CEC Receive Bit Timing Decoder

This block watches an already synchronised CEC line and turns its low and high pulses into protocol events. A tick enable at the 32.768 kHz timing rate drives a single counter. Every duration is therefore measured in ticks, and every comparison limit is also given in ticks. The counter restarts on each falling edge. The low time is captured at the following rising edge, and the total bit period is read at the next falling edge. The high time is the difference between these two values.

A frame opens with a start bit. Its low time, high time and period must each fall inside their own inclusive windows. Data bits are classed by their low time: a short low is a one and a longer low is a zero. Bits are collected most significant first into symbols of ten: eight data bits, an end-of-message bit and an acknowledge bit. A complete symbol is reported as soon as its tenth bit is classified. A timing violation raises a one-cycle error strobe, and the decoder then waits for a new start bit. A high level that outlasts the high limit after a symbol whose end-of-message bit is set closes the frame quietly.

The limits arrive on input ports, so a register bank or fixed wiring can supply them. The package carries nominal values rounded to the nearest tick, for use as reset values of such a bank. The block does not drive the line.

Top module: `cecrx_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `start_o`, `sym_vld_o` and `err_o` are low.
- R2: A low/high pair is a valid start bit when its low time, its high time and its total period are each inside their inclusive windows. A valid start bit raises `start_o` for one cycle, in the cycle after the falling edge that ends it.
- R3: If the first low of a candidate start bit ends below the low minimum, or is still low after exceeding the low maximum, `err_o` pulses and no `start_o` follows.
- R4: After an accepted start low, `err_o` pulses instead of `start_o` in two cases: the high time exceeds its maximum while the line is still high, or, at the ending falling edge, the high time or the total period lies outside its window.
- R5: A data bit with low time inside the one-window (inclusive) is a 1, and a data bit with low time inside the zero-window is a 0. A data bit whose low time lies in neither window causes `err_o` at its rising edge.
- R6: Ten data bits after a start bit form one symbol. `sym_vld_o` pulses one cycle after the rising edge of the tenth bit. `sym_o[9:2]` holds the first eight bits, with the first received bit in bit 9. `sym_o[1]` is the ninth bit (end of message) and `sym_o[0]` is the tenth bit (acknowledge).
- R7: A data bit whose total period, measured from its falling edge to the next falling edge, is below the bit-period minimum causes `err_o` at that next falling edge.
- R8: Once a data-bit low reaches the long-low threshold while the line is still low, `err_o` pulses.
- R9: In a data-bit high phase, a high time above the high maximum ends the frame with no strobe when it follows a complete symbol whose end-of-message bit is 1. In every other case it raises `err_o`.
- R10: The counter advances only in cycles where `tick_i` is high. The decoded result therefore depends only on durations counted in ticks, not on the tick rate.
- R11: Outside an accepted frame, low pulses never produce `start_o` or `sym_vld_o`, except through a valid start bit. A stray short low gives only `err_o`.
- R12: At most one of `start_o`, `sym_vld_o` and `err_o` is high in any cycle, and each stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timing tick enable (32.768 kHz rate) |
| line_i | input | 1 | Synchronised CEC line level, 1 = released |
| lim_st_low_min | input | CW | Start bit low time minimum (ticks) |
| lim_st_low_max | input | CW | Start bit low time maximum |
| lim_st_high_min | input | CW | Start bit high time minimum |
| lim_st_high_max | input | CW | Start bit high time maximum |
| lim_st_tot_min | input | CW | Start bit period minimum |
| lim_st_tot_max | input | CW | Start bit period maximum |
| lim_one_min | input | CW | Logic 1 low time minimum |
| lim_one_max | input | CW | Logic 1 low time maximum |
| lim_zero_min | input | CW | Logic 0 low time minimum |
| lim_zero_max | input | CW | Logic 0 low time maximum |
| lim_bit_tot_min | input | CW | Data bit period minimum |
| lim_high_max | input | CW | Data bit high time maximum |
| lim_long_low | input | CW | Long-low error threshold |
| start_o | output | 1 | Start bit accepted strobe |
| sym_vld_o | output | 1 | Symbol complete strobe |
| sym_o | output | 10 | Data[7:0], end of message, acknowledge |
| err_o | output | 1 | Timing error strobe |

## Verification
The embedded assertions are checked on every cycle. They cover strobe exclusivity and single-cycle width, a quiet output after reset, and the counter holding when no tick arrives. They also check the line level that must accompany each strobe: low after an accepted start, high after a completed symbol. Only the bench scenarios can show which strobe a given pulse sequence earns. These include inclusive window edges, the data bit order within a symbol, the error raised for each out-of-window duration, the quiet frame end after an end-of-message symbol, and identical decoding at two different tick rates.

// File: rtl/cecrx_pkg.sv
package cecrx_pkg;

    localparam int SYM_W = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOW,
        ST_SHIGH,
        ST_BLOW,
        ST_BHIGH
    } rx_state_e;

    typedef enum logic [1:0] {
        BIT_BAD,
        BIT_ZERO,
        BIT_ONE
    } bit_cls_e;

    typedef struct packed {
        logic [7:0] data;
        logic       eom;
        logic       ack;
    } rx_sym_t;

    // Nominal limits in 32.768 kHz ticks, rounded to the nearest tick
    localparam int DEF_ST_LOW_MIN  = 115;  // 3.5 ms
    localparam int DEF_ST_LOW_MAX  = 128;  // 3.9 ms
    localparam int DEF_ST_HIGH_MIN = 20;   // 0.6 ms
    localparam int DEF_ST_HIGH_MAX = 33;   // 1.0 ms
    localparam int DEF_ST_TOT_MIN  = 141;  // 4.3 ms
    localparam int DEF_ST_TOT_MAX  = 154;  // 4.7 ms
    localparam int DEF_ONE_MIN     = 13;   // 0.4 ms
    localparam int DEF_ONE_MAX     = 26;   // 0.8 ms
    localparam int DEF_ZERO_MIN    = 43;   // 1.3 ms
    localparam int DEF_ZERO_MAX    = 56;   // 1.7 ms
    localparam int DEF_BIT_TOT_MIN = 67;   // 2.05 ms
    localparam int DEF_HIGH_MAX    = 92;   // 2.8 ms
    localparam int DEF_LONG_LOW    = 111;  // 3.4 ms

endpackage

// File: rtl/cecrx_timer.sv
module cecrx_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          line_i,
    output logic          line_q_o,
    output logic          fall_o,
    output logic          rise_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_SAT = {CW{1'b1}};

    assign fall_o = line_q_o & ~line_i;
    assign rise_o = ~line_q_o & line_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q_o <= 1'b1;
            cnt_o    <= '0;
        end else begin
            line_q_o <= line_i;
            if (fall_o)
                cnt_o <= {{(CW-1){1'b0}}, tick_i};
            else if (tick_i && cnt_o != CNT_SAT)
                cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !fall_o) |=> $stable(cnt_o));  // R10

endmodule

// File: rtl/cecrx_classify.sv
module cecrx_classify
    import cecrx_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] low_len,
    input  logic [CW-1:0] st_low_min,
    input  logic [CW-1:0] st_low_max,
    input  logic [CW-1:0] st_high_min,
    input  logic [CW-1:0] st_high_max,
    input  logic [CW-1:0] st_tot_min,
    input  logic [CW-1:0] st_tot_max,
    input  logic [CW-1:0] one_min,
    input  logic [CW-1:0] one_max,
    input  logic [CW-1:0] zero_min,
    input  logic [CW-1:0] zero_max,
    input  logic [CW-1:0] bit_tot_min,
    input  logic [CW-1:0] high_max,
    input  logic [CW-1:0] long_low,
    output logic          st_low_ok,
    output logic          st_low_over,
    output logic          st_high_ok,
    output logic          st_high_over,
    output logic          st_tot_ok,
    output bit_cls_e      bit_cls,
    output logic          bit_long,
    output logic          bit_tot_short,
    output logic          bit_high_over
);
    function automatic logic in_win(input logic [CW-1:0] v,
                                    input logic [CW-1:0] lo,
                                    input logic [CW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    logic [CW-1:0] hi_len;
    assign hi_len = cnt - low_len;

    assign st_low_ok     = in_win(cnt, st_low_min, st_low_max);
    assign st_low_over   = cnt > st_low_max;
    assign st_high_ok    = in_win(hi_len, st_high_min, st_high_max);
    assign st_high_over  = hi_len > st_high_max;
    assign st_tot_ok     = in_win(cnt, st_tot_min, st_tot_max);
    assign bit_long      = cnt >= long_low;
    assign bit_tot_short = cnt < bit_tot_min;
    assign bit_high_over = hi_len > high_max;

    always_comb begin
        if (in_win(cnt, one_min, one_max))
            bit_cls = BIT_ONE;
        else if (in_win(cnt, zero_min, zero_max))
            bit_cls = BIT_ZERO;
        else
            bit_cls = BIT_BAD;
    end

endmodule

// File: rtl/cecrx_decoder.sv
module cecrx_decoder
    import cecrx_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             line_i,
    input  logic [CW-1:0]    lim_st_low_min,
    input  logic [CW-1:0]    lim_st_low_max,
    input  logic [CW-1:0]    lim_st_high_min,
    input  logic [CW-1:0]    lim_st_high_max,
    input  logic [CW-1:0]    lim_st_tot_min,
    input  logic [CW-1:0]    lim_st_tot_max,
    input  logic [CW-1:0]    lim_one_min,
    input  logic [CW-1:0]    lim_one_max,
    input  logic [CW-1:0]    lim_zero_min,
    input  logic [CW-1:0]    lim_zero_max,
    input  logic [CW-1:0]    lim_bit_tot_min,
    input  logic [CW-1:0]    lim_high_max,
    input  logic [CW-1:0]    lim_long_low,
    output logic             start_o,
    output logic             sym_vld_o,
    output logic [SYM_W-1:0] sym_o,
    output logic             err_o
);
    localparam int BIDX_W = $clog2(SYM_W);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(SYM_W - 1);

    logic          line_q, fall, rise;
    logic [CW-1:0] cnt;
    logic [CW-1:0] low_len;

    logic     st_low_ok, st_low_over, st_high_ok, st_high_over, st_tot_ok;
    logic     bit_long, bit_tot_short, bit_high_over;
    bit_cls_e bit_cls;
    logic     bit_val;

    rx_state_e        st;
    logic [SYM_W-2:0] sh;
    logic [BIDX_W-1:0] bidx;
    logic             eom_last;

    cecrx_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .line_i   (line_i),
        .line_q_o (line_q),
        .fall_o   (fall),
        .rise_o   (rise),
        .cnt_o    (cnt)
    );

    cecrx_classify #(.CW(CW)) u_cls (
        .cnt           (cnt),
        .low_len       (low_len),
        .st_low_min    (lim_st_low_min),
        .st_low_max    (lim_st_low_max),
        .st_high_min   (lim_st_high_min),
        .st_high_max   (lim_st_high_max),
        .st_tot_min    (lim_st_tot_min),
        .st_tot_max    (lim_st_tot_max),
        .one_min       (lim_one_min),
        .one_max       (lim_one_max),
        .zero_min      (lim_zero_min),
        .zero_max      (lim_zero_max),
        .bit_tot_min   (lim_bit_tot_min),
        .high_max      (lim_high_max),
        .long_low      (lim_long_low),
        .st_low_ok     (st_low_ok),
        .st_low_over   (st_low_over),
        .st_high_ok    (st_high_ok),
        .st_high_over  (st_high_over),
        .st_tot_ok     (st_tot_ok),
        .bit_cls       (bit_cls),
        .bit_long      (bit_long),
        .bit_tot_short (bit_tot_short),
        .bit_high_over (bit_high_over)
    );

    assign bit_val = (bit_cls == BIT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            low_len   <= '0;
            sh        <= '0;
            bidx      <= '0;
            eom_last  <= 1'b0;
            start_o   <= 1'b0;
            sym_vld_o <= 1'b0;
            sym_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            start_o   <= 1'b0;
            sym_vld_o <= 1'b0;
            err_o     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (fall) st <= ST_SLOW;
                end
                ST_SLOW: begin
                    if (rise) begin
                        low_len <= cnt;
                        if (st_low_ok) begin
                            st <= ST_SHIGH;
                        end else begin
                            err_o <= 1'b1;
                            st    <= ST_IDLE;
                        end
                    end else if (st_low_over) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_SHIGH: begin
                    if (fall) begin
                        if (st_high_ok && st_tot_ok) begin
                            start_o  <= 1'b1;
                            bidx     <= '0;
                            eom_last <= 1'b0;
                            st       <= ST_BLOW;
                        end else begin
                            err_o <= 1'b1;
                            st    <= ST_IDLE;
                        end
                    end else if (st_high_over) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_BLOW: begin
                    if (rise) begin
                        low_len <= cnt;
                        if (bit_cls == BIT_BAD) begin
                            err_o <= 1'b1;
                            st    <= ST_IDLE;
                        end else begin
                            st <= ST_BHIGH;
                            if (bidx == LAST_IDX) begin
                                sym_o     <= {sh, bit_val};
                                sym_vld_o <= 1'b1;
                                eom_last  <= sh[0];
                                bidx      <= '0;
                            end else begin
                                sh   <= {sh[SYM_W-3:0], bit_val};
                                bidx <= bidx + 1'b1;
                            end
                        end
                    end else if (bit_long) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_BHIGH: begin
                    if (fall) begin
                        if (bit_tot_short) begin
                            err_o <= 1'b1;
                            st    <= ST_IDLE;
                        end else begin
                            st <= ST_BLOW;
                        end
                    end else if (bit_high_over) begin
                        if (!(bidx == '0 && eom_last))
                            err_o <= 1'b1;
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, sym_vld_o, err_o}));  // R12
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);  // R2
    AST_SYM_PULSE: assert property (@(posedge clk) disable iff (rst)
        sym_vld_o |=> !sym_vld_o);  // R6
    AST_START_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !line_q);  // R2
    AST_SYM_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sym_vld_o |-> line_q);  // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(start_o || sym_vld_o || err_o));  // R1

endmodule

// File: tb/cecrx_decoder_test.sv
module cecrx_decoder_test;
    import cecrx_pkg::*;

    localparam int CW = 10;

    typedef struct packed {
        logic [1:0]  kind;   // 0 start, 1 symbol, 2 error
        logic [9:0]  sym;
        logic [31:0] tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic line = 1'b1;
    logic start_o, sym_vld_o, err_o;
    logic [SYM_W-1:0] sym_o;

    int n_checks = 0;
    int n_fail = 0;
    int tick_div = 1;
    int ph = 0;
    bit done = 0;
    exp_item_t exp_q[$];
    exp_item_t it;
    logic [1:0] kind_now;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (ph >= tick_div - 1) ph = 0;
        else ph = ph + 1;
        tick = (ph == 0);
    end

    cecrx_decoder #(.CW(CW)) uut (
        .clk(clk), .rst(rst), .tick_i(tick), .line_i(line),
        .lim_st_low_min (10'(DEF_ST_LOW_MIN)),
        .lim_st_low_max (10'(DEF_ST_LOW_MAX)),
        .lim_st_high_min(10'(DEF_ST_HIGH_MIN)),
        .lim_st_high_max(10'(DEF_ST_HIGH_MAX)),
        .lim_st_tot_min (10'(DEF_ST_TOT_MIN)),
        .lim_st_tot_max (10'(DEF_ST_TOT_MAX)),
        .lim_one_min    (10'(DEF_ONE_MIN)),
        .lim_one_max    (10'(DEF_ONE_MAX)),
        .lim_zero_min   (10'(DEF_ZERO_MIN)),
        .lim_zero_max   (10'(DEF_ZERO_MAX)),
        .lim_bit_tot_min(10'(DEF_BIT_TOT_MIN)),
        .lim_high_max   (10'(DEF_HIGH_MAX)),
        .lim_long_low   (10'(DEF_LONG_LOW)),
        .start_o(start_o), .sym_vld_o(sym_vld_o), .sym_o(sym_o), .err_o(err_o)
    );

    // Monitor: pops the scoreboard whenever a strobe appears
    always @(negedge clk) begin
        if (!rst && (start_o || sym_vld_o || err_o)) begin
            kind_now = start_o ? 2'd0 : (sym_vld_o ? 2'd1 : 2'd2);
            n_checks++;
            if ($countones({start_o, sym_vld_o, err_o}) > 1) begin
                n_fail++;
                $display("FAIL R12 strobes %b expected at most one", {start_o, sym_vld_o, err_o});
            end else if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected strobe kind %0d sym %h, expected none", kind_now, sym_o);
            end else begin
                it = exp_q.pop_front();
                if (it.kind != kind_now || (kind_now == 2'd1 && it.sym != sym_o)) begin
                    n_fail++;
                    $display("FAIL %s kind %0d sym %h, expected kind %0d sym %h",
                             it.tag, kind_now, sym_o, it.kind, it.sym);
                end
            end
        end
    end

    task automatic expect_ev(input logic [1:0] k, input logic [9:0] s, input logic [31:0] tg);
        exp_item_t e;
        e.kind = k; e.sym = s; e.tag = tg;
        exp_q.push_back(e);
    endtask

    task automatic hold(input logic lvl, input int n);
        int k;
        line = lvl;
        k = 0;
        while (k < n) begin
            @(posedge clk);
            if (tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic send_start(input int lo, input int hi);
        hold(1'b0, lo);
        hold(1'b1, hi);
    endtask

    task automatic send_bit(input logic b);
        hold(1'b0, b ? 20 : 49);
        hold(1'b1, b ? 60 : 31);
    endtask

    task automatic send_raw(input int lo, input int tot);
        hold(1'b0, lo);
        hold(1'b1, tot - lo);
    endtask

    task automatic send_sym(input logic [7:0] d, input logic eom, input logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(eom);
        send_bit(ack);
    endtask

    function automatic logic [9:0] mk(input logic [7:0] d, input logic eom, input logic ack);
        rx_sym_t s;
        s.data = d; s.eom = eom; s.ack = ack;
        return s;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        n_checks++;
        if (start_o || sym_vld_o || err_o) begin
            n_fail++;
            $display("FAIL R1 strobes %b expected 000", {start_o, sym_vld_o, err_o});
        end
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (start_o || sym_vld_o || err_o) begin
            n_fail++;
            $display("FAIL R1 after release strobes %b expected 000", {start_o, sym_vld_o, err_o});
        end
        hold(1'b1, 20);

        // R2 R6 R9: two symbols, second with end of message, then quiet end
        expect_ev(2'd0, 10'h0, "R2");
        expect_ev(2'd1, mk(8'hA5, 1'b0, 1'b1), "R6");
        expect_ev(2'd1, mk(8'h3C, 1'b1, 1'b0), "R6");
        send_start(122, 27);
        send_sym(8'hA5, 1'b0, 1'b1);
        send_sym(8'h3C, 1'b1, 1'b0);
        hold(1'b1, 200);

        // R5 R2: inclusive window edges, bit period exactly at its minimum
        expect_ev(2'd0, 10'h0, "R2");
        expect_ev(2'd1, mk(8'hCA, 1'b1, 1'b1), "R5");
        send_start(128, 20);
        send_raw(13, 67); send_raw(26, 67); send_raw(43, 67); send_raw(56, 67);
        send_raw(13, 67); send_raw(56, 67); send_raw(26, 67); send_raw(43, 67);
        send_raw(13, 67); send_raw(26, 67);
        hold(1'b1, 200);
        expect_ev(2'd0, 10'h0, "R2");
        expect_ev(2'd1, mk(8'h00, 1'b1, 1'b0), "R6");
        send_start(115, 33);
        send_sym(8'h00, 1'b1, 1'b0);
        hold(1'b1, 200);

        // R10: slower tick, same durations in ticks, same result
        tick_div = 3;
        expect_ev(2'd0, 10'h0, "R10");
        expect_ev(2'd1, mk(8'h81, 1'b1, 1'b1), "R10");
        send_start(122, 27);
        send_sym(8'h81, 1'b1, 1'b1);
        hold(1'b1, 200);
        tick_div = 1;
        hold(1'b1, 5);

        // R3: start low too short, then too long
        expect_ev(2'd2, 10'h0, "R3");
        hold(1'b0, 100); hold(1'b1, 200);
        expect_ev(2'd2, 10'h0, "R3");
        hold(1'b0, 140); hold(1'b1, 200);

        // R4: start high too long, then period too short
        expect_ev(2'd2, 10'h0, "R4");
        send_start(122, 200);
        expect_ev(2'd2, 10'h0, "R4");
        send_start(116, 20);
        hold(1'b0, 20); hold(1'b1, 200);

        // R11: stray data-like lows outside a frame give errors only
        for (int i = 0; i < 3; i++) begin
            expect_ev(2'd2, 10'h0, "R11");
            send_bit(1'b1);
        end
        hold(1'b1, 200);

        // R5: low time between the one and zero windows
        expect_ev(2'd0, 10'h0, "R5");
        expect_ev(2'd2, 10'h0, "R5");
        send_start(122, 27);
        hold(1'b0, 35); hold(1'b1, 200);

        // R7: data bit period too short
        expect_ev(2'd0, 10'h0, "R7");
        expect_ev(2'd2, 10'h0, "R7");
        send_start(122, 27);
        hold(1'b0, 20); hold(1'b1, 30);
        hold(1'b0, 20); hold(1'b1, 200);

        // R8: long low inside a frame
        expect_ev(2'd0, 10'h0, "R8");
        expect_ev(2'd2, 10'h0, "R8");
        send_start(122, 27);
        hold(1'b0, 115); hold(1'b1, 200);

        // R9: timeout after a symbol without end of message
        expect_ev(2'd0, 10'h0, "R9");
        expect_ev(2'd1, mk(8'h55, 1'b0, 1'b1), "R9");
        expect_ev(2'd2, 10'h0, "R9");
        send_start(122, 27);
        send_sym(8'h55, 1'b0, 1'b1);
        hold(1'b1, 200);

        // R9: timeout in the middle of a symbol
        expect_ev(2'd0, 10'h0, "R9");
        expect_ev(2'd2, 10'h0, "R9");
        send_start(122, 27);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        hold(1'b1, 200);

        repeat (50) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6 missing %0d expected strobes, expected 0 pending", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, %0d expected strobes pending, expected 0", exp_q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule